// File: doc/BRIEF.md
# Legacy Keyboard Controller Emulation Trap

This block lets host software stand in for an old-style keyboard controller. Accesses to the controller's data port (60h) and command/status port (64h) arrive on a trapped port-access bus. A write to either port leaves its byte in an input register, raises input-full and records which of the two ports was hit. A read of the data port returns the byte that software placed in the output register. A read of the command/status port returns a legacy-layout status byte. The block also follows the "write output port" command sequence, so a gate-A20 byte written through the data port reaches an A20 state bit with no software involved.

Emulation software reaches the block through a small register bus with four byte registers: control, input (read only), status and output. An emulation interrupt tells software that a trapped access happened. Keyboard and auxiliary-device interrupt flags follow output-full and are cleared by writing 1 to them.

Top module: `kbc_emu`

## Requirements
- R1: A port write (`io_wr`) latches `io_wdata` into the input register (register address 1) and sets input-full (status bit 1). Status bit 3 records the port written: 0 for the data port (`io_sel`=0), 1 for the command port (`io_sel`=1).
- R2: A register write to the output register (address 3) stores the byte and sets output-full (status bit 0). A data-port read (`io_rd`, `io_sel`=0) returns that byte on `io_rdata` and clears output-full.
- R3: A command-port read returns the status byte: b0 output-full, b1 input-full, b2 boot flag, b3 last port written, b4 keyboard enabled (0 = inhibited), b5 aux output-full, b6 time-out, b7 parity error. A register write to status (address 2) loads bits 7,6,5,4,2. Writing 0 to bits 1 or 0 clears that bit, and writing 1 to them has no effect. Bit 3 is read only.
- R4: Writing D1h to the command port arms an internal sequence flag. Writing any other value to the command port disarms it.
- R5: A data-port write while the flag is armed loads the A20 state (control bit 4) from data bit 1 and disarms the flag. A data-port write while the flag is not armed leaves A20 unchanged.
- R6: Control register (address 0): b0 emulation enable, b1 IRQ enable, b2 external-IRQ emulation enable, b3 character-pending emulation enable, b4 A20 state. Bits 0-4 are read/write. b5 is the read-only emulation condition. b6 IRQ1-active and b7 IRQ12-active are cleared by writing 1, and writing 0 to them has no effect.
- R7: On each cycle where output-full and IRQ enable are both 1, the IRQ12-active flag is set if aux output-full is 1, and otherwise the IRQ1-active flag is set. `irq_kbd` and `irq_aux` show the flags. A set condition wins over a write-1 clear in the same cycle.
- R8: Any trapped port access while emulation is enabled sets the emulation condition, which is shown on `irq_emu`. A status register write with bit 1 = 0 clears it. Accesses while emulation is disabled do not set it.
- R9: After reset: control = 00h, status = 10h, input = 00h, output = 00h, and all three interrupt outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| io_wr | input | 1 | Trapped port write strobe |
| io_rd | input | 1 | Trapped port read strobe |
| io_sel | input | 1 | Port select: 0 data port, 1 command/status port |
| io_wdata | input | 8 | Byte written by the trapped access |
| io_rdata | output | 8 | Byte returned to the trapped read |
| reg_wr | input | 1 | Register bus write strobe |
| reg_addr | input | 2 | Register address: 0 control, 1 input, 2 status, 3 output |
| reg_wdata | input | 8 | Register bus write data |
| reg_rdata | output | 8 | Register bus read data for `reg_addr` |
| irq_emu | output | 1 | Emulation interrupt |
| irq_kbd | output | 1 | Keyboard interrupt (IRQ1-active) |
| irq_aux | output | 1 | Auxiliary interrupt (IRQ12-active) |

## Verification
The hardest state to reach from the ports is the sequence flag, because it has no visible bit. It is reached by sweeping all 256 command bytes. Each command write is followed by two data writes, 0xFF and then 0x00. A20 is 1 after this only when the command was D1h, and it stays 1 only if the first data write disarmed the flag. The interrupt flags have a set-wins priority. This is reached by issuing a write-1 clear while output-full is still held, and then again after a data-port read has dropped output-full.

// File: rtl/kbc_emu_pkg.sv
// Package kbc_emu_pkg
// Shared register addresses, bit positions and constants for the keyboard
// controller emulation block. Assumes byte-wide legacy ports.
package kbc_emu_pkg;
    typedef enum logic [1:0] {
        RA_CTRL = 2'd0,
        RA_IN   = 2'd1,
        RA_STAT = 2'd2,
        RA_OUT  = 2'd3
    } kbc_reg_e;

    // Status bit positions, fixed because legacy software decodes them.
    localparam int ST_OBF  = 0;
    localparam int ST_IBF  = 1;
    localparam int ST_BOOT = 2;
    localparam int ST_CMD  = 3;
    localparam int ST_KEN  = 4;
    localparam int ST_AUX  = 5;
    localparam int ST_TO   = 6;
    localparam int ST_PAR  = 7;

    // Control bit positions.
    localparam int CT_EMU  = 0;
    localparam int CT_IRQ  = 1;
    localparam int CT_EXT  = 2;
    localparam int CT_CHR  = 3;
    localparam int CT_A20  = 4;
    localparam int CT_COND = 5;
    localparam int CT_KBDF = 6;
    localparam int CT_AUXF = 7;

    // Number of interrupt flags (keyboard, auxiliary).
    localparam int NUM_IRQ_FLAGS = 2;
endpackage

// File: rtl/kbc_emu_trap.sv
// Module kbc_emu_trap
// Captures trapped port writes: input byte, input-full, last port written,
// and the armed state of the A20 "write output port" sequence.
// Assumes at most one of io_wr/io_rd per cycle; a port write wins over a
// same-cycle software clear of input-full.
module kbc_emu_trap #(
    parameter int          DATA_W  = 8,
    parameter logic [7:0]  A20_CMD = 8'hD1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              io_wr,
    input  logic              io_sel,
    input  logic [DATA_W-1:0] io_wdata,
    input  logic              in_clr,
    output logic [DATA_W-1:0] in_data,
    output logic              in_full,
    output logic              last_cmd,
    output logic              seq_armed,
    output logic              a20_load,
    output logic              a20_val
);
    // Data-port write while armed delivers the A20 bit this cycle.
    assign a20_load = io_wr && !io_sel && seq_armed;
    assign a20_val  = io_wdata[1];

    // Latch written byte, port identity, input-full and sequence state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            in_data   <= '0;
            in_full   <= 1'b0;
            last_cmd  <= 1'b0;
            seq_armed <= 1'b0;
        end else if (io_wr) begin
            in_data   <= io_wdata;
            in_full   <= 1'b1;
            last_cmd  <= io_sel;
            seq_armed <= io_sel && (io_wdata[7:0] == A20_CMD);
        end else if (in_clr) begin
            in_full   <= 1'b0;
        end
    end

    a_r1_write_sets_full: assert property (@(posedge clk) disable iff (!rst_n)
        io_wr |=> in_full && in_data == $past(io_wdata));
    a_r1_port_recorded: assert property (@(posedge clk) disable iff (!rst_n)
        io_wr |=> last_cmd == $past(io_sel));
    a_r4_arm_on_cmd: assert property (@(posedge clk) disable iff (!rst_n)
        (io_wr && io_sel && io_wdata[7:0] == A20_CMD) |=> seq_armed);
    a_r5_disarm_on_data: assert property (@(posedge clk) disable iff (!rst_n)
        (io_wr && !io_sel) |=> !seq_armed);
endmodule

// File: rtl/kbc_emu_irq.sv
// Module kbc_emu_irq
// Holds the emulation condition and the keyboard/auxiliary interrupt flags.
// Assumes set conditions take priority over software clears.
module kbc_emu_irq
    import kbc_emu_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic emu_en,
    input  logic irq_en,
    input  logic io_acc,
    input  logic cond_clr,
    input  logic out_full,
    input  logic aux_full,
    input  logic w1c_kbd,
    input  logic w1c_aux,
    output logic emu_cond,
    output logic kbd_flag,
    output logic aux_flag
);
    logic [NUM_IRQ_FLAGS-1:0] set_v, clr_v, flag_q;

    assign set_v = {out_full & irq_en & aux_full, out_full & irq_en & ~aux_full};
    assign clr_v = {w1c_aux, w1c_kbd};
    assign kbd_flag = flag_q[0];
    assign aux_flag = flag_q[1];

    // Emulation condition: set on an access while enabled, cleared by software.
    always_ff @(posedge clk) begin
        if (!rst_n)                 emu_cond <= 1'b0;
        else if (emu_en && io_acc)  emu_cond <= 1'b1;
        else if (cond_clr)          emu_cond <= 1'b0;
    end

    // One set-dominant write-1-clear flag per interrupt source.
    for (genvar g = 0; g < NUM_IRQ_FLAGS; g++) begin : g_flag
        always_ff @(posedge clk) begin
            if (!rst_n)         flag_q[g] <= 1'b0;
            else if (set_v[g])  flag_q[g] <= 1'b1;
            else if (clr_v[g])  flag_q[g] <= 1'b0;
        end
    end

    a_r7_kbd_raise: assert property (@(posedge clk) disable iff (!rst_n)
        (out_full && irq_en && !aux_full) |=> kbd_flag);
    a_r7_aux_raise: assert property (@(posedge clk) disable iff (!rst_n)
        (out_full && irq_en && aux_full) |=> aux_flag);
    a_r8_cond_set: assert property (@(posedge clk) disable iff (!rst_n)
        (emu_en && io_acc) |=> emu_cond);
    a_r8_cond_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (cond_clr && !(emu_en && io_acc)) |=> !emu_cond);
endmodule

// File: rtl/kbc_emu.sv
// Module kbc_emu (top)
// Legacy keyboard controller emulation trap: control/status/output storage,
// register bus decode and trapped-read return path.
// Assumes single-cycle strobes; read data paths are combinational.
module kbc_emu
    import kbc_emu_pkg::*;
#(
    parameter int         DATA_W     = 8,
    parameter logic [7:0] A20_CMD    = 8'hD1,
    parameter logic [7:0] STAT_RESET = 8'h10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              io_wr,
    input  logic              io_rd,
    input  logic              io_sel,
    input  logic [DATA_W-1:0] io_wdata,
    output logic [DATA_W-1:0] io_rdata,
    input  logic              reg_wr,
    input  logic [1:0]        reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              irq_emu,
    output logic              irq_kbd,
    output logic              irq_aux
);
    logic              wr_ctrl, wr_stat, wr_out;
    logic [DATA_W-1:0] in_data, out_data, status, control;
    logic              in_full, last_cmd, seq_armed, a20_load, a20_val;
    logic              emu_cond, kbd_flag, aux_flag;
    logic              ctl_emu, ctl_irq, ctl_ext, ctl_chr, a20;
    logic              out_full, st_boot, st_ken, st_aux, st_to, st_par;

    assign wr_ctrl = reg_wr && (reg_addr == RA_CTRL);
    assign wr_stat = reg_wr && (reg_addr == RA_STAT);
    assign wr_out  = reg_wr && (reg_addr == RA_OUT);

    kbc_emu_trap #(.DATA_W(DATA_W), .A20_CMD(A20_CMD)) u_trap (
        .clk       (clk),
        .rst_n     (rst_n),
        .io_wr     (io_wr),
        .io_sel    (io_sel),
        .io_wdata  (io_wdata),
        .in_clr    (wr_stat && !reg_wdata[ST_IBF]),
        .in_data   (in_data),
        .in_full   (in_full),
        .last_cmd  (last_cmd),
        .seq_armed (seq_armed),
        .a20_load  (a20_load),
        .a20_val   (a20_val)
    );

    kbc_emu_irq u_irq (
        .clk      (clk),
        .rst_n    (rst_n),
        .emu_en   (ctl_emu),
        .irq_en   (ctl_irq),
        .io_acc   (io_wr || io_rd),
        .cond_clr (wr_stat && !reg_wdata[ST_IBF]),
        .out_full (out_full),
        .aux_full (st_aux),
        .w1c_kbd  (wr_ctrl && reg_wdata[CT_KBDF]),
        .w1c_aux  (wr_ctrl && reg_wdata[CT_AUXF]),
        .emu_cond (emu_cond),
        .kbd_flag (kbd_flag),
        .aux_flag (aux_flag)
    );

    // Control bits written by software; the A20 sequence overrides A20.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            {ctl_emu, ctl_irq, ctl_ext, ctl_chr, a20} <= '0;
        end else begin
            if (wr_ctrl) begin
                ctl_emu <= reg_wdata[CT_EMU];
                ctl_irq <= reg_wdata[CT_IRQ];
                ctl_ext <= reg_wdata[CT_EXT];
                ctl_chr <= reg_wdata[CT_CHR];
            end
            if (a20_load)      a20 <= a20_val;
            else if (wr_ctrl)  a20 <= reg_wdata[CT_A20];
        end
    end

    // Output byte and output-full: a load wins over a read or a clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_data <= '0;
            out_full <= 1'b0;
        end else if (wr_out) begin
            out_data <= reg_wdata;
            out_full <= 1'b1;
        end else if ((io_rd && !io_sel) || (wr_stat && !reg_wdata[ST_OBF])) begin
            out_full <= 1'b0;
        end
    end

    // Software-owned status bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_boot <= STAT_RESET[ST_BOOT];
            st_ken  <= STAT_RESET[ST_KEN];
            st_aux  <= STAT_RESET[ST_AUX];
            st_to   <= STAT_RESET[ST_TO];
            st_par  <= STAT_RESET[ST_PAR];
        end else if (wr_stat) begin
            st_boot <= reg_wdata[ST_BOOT];
            st_ken  <= reg_wdata[ST_KEN];
            st_aux  <= reg_wdata[ST_AUX];
            st_to   <= reg_wdata[ST_TO];
            st_par  <= reg_wdata[ST_PAR];
        end
    end

    // Assemble status and control views.
    always_comb begin
        status          = '0;
        status[ST_OBF]  = out_full;
        status[ST_IBF]  = in_full;
        status[ST_BOOT] = st_boot;
        status[ST_CMD]  = last_cmd;
        status[ST_KEN]  = st_ken;
        status[ST_AUX]  = st_aux;
        status[ST_TO]   = st_to;
        status[ST_PAR]  = st_par;
        control          = '0;
        control[CT_EMU]  = ctl_emu;
        control[CT_IRQ]  = ctl_irq;
        control[CT_EXT]  = ctl_ext;
        control[CT_CHR]  = ctl_chr;
        control[CT_A20]  = a20;
        control[CT_COND] = emu_cond;
        control[CT_KBDF] = kbd_flag;
        control[CT_AUXF] = aux_flag;
    end

    // Register bus read mux.
    always_comb begin
        case (reg_addr)
            RA_CTRL: reg_rdata = control;
            RA_IN:   reg_rdata = in_data;
            RA_STAT: reg_rdata = status;
            default: reg_rdata = out_data;
        endcase
    end

    assign io_rdata = io_sel ? status : out_data;
    assign irq_emu  = emu_cond;
    assign irq_kbd  = kbd_flag;
    assign irq_aux  = aux_flag;

    a_r2_read_clears_full: assert property (@(posedge clk) disable iff (!rst_n)
        (io_rd && !io_sel && !wr_out) |=> !out_full);
    a_r2_load_sets_full: assert property (@(posedge clk) disable iff (!rst_n)
        wr_out |=> out_full && out_data == $past(reg_wdata));
    a_r5_a20_from_data: assert property (@(posedge clk) disable iff (!rst_n)
        (io_wr && !io_sel && seq_armed) |=> a20 == $past(io_wdata[1]));
    a_r5_a20_held: assert property (@(posedge clk) disable iff (!rst_n)
        (io_wr && !io_sel && !seq_armed && !wr_ctrl) |=> $stable(a20));
    a_r3_cmd_bit_ro: assert property (@(posedge clk) disable iff (!rst_n)
        (!io_wr) |=> $stable(last_cmd));
endmodule

// File: tb/kbc_emu_tb.sv
module kbc_emu_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       io_wr = 1'b0, io_rd = 1'b0, io_sel = 1'b0;
    logic [7:0] io_wdata = '0;
    logic [7:0] io_rdata;
    logic       reg_wr = 1'b0;
    logic [1:0] reg_addr = '0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       irq_emu, irq_kbd, irq_aux;
    int         checks = 0;
    int         fails = 0;
    bit         done = 1'b0;

    always #2 clk = ~clk;

    kbc_emu u_dut (
        .clk(clk), .rst_n(rst_n),
        .io_wr(io_wr), .io_rd(io_rd), .io_sel(io_sel),
        .io_wdata(io_wdata), .io_rdata(io_rdata),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata),
        .irq_emu(irq_emu), .irq_kbd(irq_kbd), .irq_aux(irq_aux)
    );

    task automatic check(string req, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic io_write(logic sel, logic [7:0] d);
        @(negedge clk);
        io_wr = 1'b1; io_sel = sel; io_wdata = d;
        @(negedge clk);
        io_wr = 1'b0;
    endtask

    task automatic io_read(logic sel, output logic [7:0] d);
        @(negedge clk);
        io_rd = 1'b1; io_sel = sel;
        #1 d = io_rdata;
        @(negedge clk);
        io_rd = 1'b0;
    endtask

    task automatic reg_write(logic [1:0] a, logic [7:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic reg_read(logic [1:0] a, output logic [7:0] d);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin : main
        logic [7:0] r;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R9 reset state
        reg_read(2'd0, r); check("R9 control", r, 8'h00);
        reg_read(2'd2, r); check("R9 status", r, 8'h10);
        reg_read(2'd1, r); check("R9 input", r, 8'h00);
        reg_read(2'd3, r); check("R9 output", r, 8'h00);
        check("R9 irqs", {5'd0, irq_emu, irq_kbd, irq_aux}, 8'h00);

        // R1 sweep over every byte on both ports
        for (int v = 0; v < 256; v++) begin
            for (int s = 0; s < 2; s++) begin
                io_write(s[0], v[7:0]);
                reg_read(2'd1, r); check("R1 input byte", r, v[7:0]);
                reg_read(2'd2, r);
                check("R1 port bit / input-full", {6'd0, r[3], r[1]}, {6'd0, s[0], 1'b1});
            end
        end

        // R4/R5 sweep of command bytes against the A20 sequence
        for (int v = 0; v < 256; v++) begin
            reg_write(2'd0, 8'h00);
            io_write(1'b1, v[7:0]);
            io_write(1'b0, 8'hFF);
            reg_read(2'd0, r); check("R4 arm by D1h", {7'd0, r[4]}, {7'd0, v == 8'hD1});
            io_write(1'b0, 8'h00);
            reg_read(2'd0, r); check("R5 flag disarmed", {7'd0, r[4]}, {7'd0, v == 8'hD1});
        end
        reg_write(2'd0, 8'h10);
        io_write(1'b0, 8'h00);
        reg_read(2'd0, r); check("R5 unarmed data write keeps A20", {7'd0, r[4]}, 8'h01);
        reg_write(2'd0, 8'h00);
        io_write(1'b1, 8'hD1);
        io_write(1'b1, 8'h20);
        io_write(1'b0, 8'h02);
        reg_read(2'd0, r); check("R4 other command disarms", {7'd0, r[4]}, 8'h00);

        // R2 output register and data-port read
        for (int v = 0; v < 256; v++) begin
            reg_write(2'd3, v[7:0]);
            reg_read(2'd2, r); check("R2 output-full set", {7'd0, r[0]}, 8'h01);
            io_read(1'b0, r); check("R2 data-port read", r, v[7:0]);
            reg_read(2'd2, r); check("R2 output-full cleared", {7'd0, r[0]}, 8'h00);
        end

        // R3 status write sweep, read back through the command port
        for (int v = 0; v < 256; v++) begin
            reg_write(2'd3, 8'h00);
            io_write(1'b1, 8'h00);
            reg_write(2'd2, v[7:0]);
            io_read(1'b1, r);
            check("R3 status write", r, (v[7:0] & 8'hF4) | 8'h08 | (v[7:0] & 8'h03));
        end
        reg_write(2'd2, 8'h10);

        // R6 control read/write sweep, emulation condition and flags idle
        for (int v = 0; v < 256; v++) begin
            reg_write(2'd0, v[7:0]);
            reg_read(2'd0, r); check("R6 control readback", r, v[7:0] & 8'h1F);
        end

        // R7 keyboard flag, set-wins, write-1 clear, aux routing
        reg_write(2'd0, 8'h02);
        reg_write(2'd3, 8'h55);
        @(negedge clk);
        check("R7 IRQ1 raised", {6'd0, irq_kbd, irq_aux}, 8'h02);
        reg_write(2'd0, 8'hC2);
        check("R7 set wins over clear", {7'd0, irq_kbd}, 8'h01);
        io_read(1'b0, r);
        reg_write(2'd0, 8'h02);
        check("R6 write 0 keeps IRQ1 flag", {7'd0, irq_kbd}, 8'h01);
        reg_write(2'd0, 8'h42);
        reg_read(2'd0, r); check("R7 IRQ1 cleared by W1C", r, 8'h02);
        reg_write(2'd2, 8'h30);
        reg_write(2'd3, 8'hAA);
        @(negedge clk);
        check("R7 IRQ12 raised with aux", {6'd0, irq_kbd, irq_aux}, 8'h01);
        io_read(1'b0, r);
        reg_write(2'd0, 8'h80);
        reg_read(2'd0, r); check("R7 IRQ12 cleared, IRQs off", r, 8'h00);
        reg_write(2'd3, 8'h11);
        @(negedge clk);
        check("R7 no flag without IRQ enable", {6'd0, irq_kbd, irq_aux}, 8'h00);
        io_read(1'b0, r);
        reg_write(2'd2, 8'h10);

        // R8 emulation condition
        io_read(1'b1, r);
        check("R8 no condition when disabled", {7'd0, irq_emu}, 8'h00);
        reg_write(2'd0, 8'h01);
        io_read(1'b1, r);
        check("R8 read sets condition", {7'd0, irq_emu}, 8'h01);
        reg_read(2'd0, r); check("R8 condition bit", r, 8'h21);
        reg_write(2'd2, 8'h10);
        check("R8 cleared by input-full clear", {7'd0, irq_emu}, 8'h00);
        io_write(1'b0, 8'h33);
        check("R8 write sets condition", {7'd0, irq_emu}, 8'h01);
        reg_write(2'd2, 8'h10);
        check("R8 cleared again", {7'd0, irq_emu}, 8'h00);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule